// File: doc/BRIEF.md
# Clamp Level Calibration Controller

This block is a hardware sequencer that finds the clamp level code for a contact image sensor front end. It runs before gain and offset calibration. On a start pulse it programs the gain register to unity and loads the clamp register with its highest code. It then requests scans from an external scan source and moves the clamp code one step at a time until the black level of a dark line falls into a target window.

The search has two phases. The first phase asks for clamp-level readings. It averages 16 samples, and while that average is zero it lowers the clamp code. The second phase asks for whole dark lines and takes the minimum pixel of each line. A minimum at or below 102 codes raises the clamp code. A minimum above 204 codes lowers it. Once the minimum sits inside the window, the offset register is set to its zero point and the block reports done. The search fails in two cases: it would have to step past code 0 or code 15, or it would need more than the allowed number of scans.

Every register write uses a request/acknowledge handshake. Every scan uses a request/acknowledge handshake followed by a stream of samples. A write is always acknowledged before the next scan is requested.

Top module: `clampcal_ctrl`

## Requirements
- R1: After reset `wr_req`, `scan_req`, `done` and `fail` are low and `clamp_code` is 15 (all ones).
- R2: A `start` pulse while idle, done or failed begins a run. Its first register write is address 2 (gain) with data 1, and its second is address 3 (clamp) with data 15.
- R3: `wr_req` holds its address and data until `wr_ack`, and `scan_req` holds `scan_dark` until `scan_ack`. `scan_req` and `wr_req` are never high together. Every clamp change is written to address 3 before the next scan.
- R4: In the average phase (`scan_dark`=0) exactly 16 valid samples are summed and shifted right by 4, and `smp_last` is ignored. A result of 0 lowers the clamp code by one, rewrites it and requests another average scan.
- R5: A non-zero average switches to dark-line scans (`scan_dark`=1). A dark scan takes the minimum over all valid samples up to and including the one flagged `smp_last`.
- R6: A dark minimum at or below 102 raises the clamp code by one, rewrites it and rescans a dark line.
- R7: A dark minimum above 204 lowers the clamp code by one, rewrites it and rescans a dark line. The clamp code only ever moves in steps of one, apart from the reload to 15 at start.
- R8: A dark minimum in the range 103 to 204 writes 0x80 to address 1 (offset), and after that write is acknowledged `done` goes high.
- R9: A needed step below 0 or above 15 ends the run with `fail`. The code is left unchanged and no further write or scan is made.
- R10: A run makes at most 32 scans. If a 33rd would be needed, `fail` is raised instead.
- R11: `done` and `fail` are never high together, and they hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (pulse) |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 3 | Register address: 1 offset, 2 gain, 3 clamp |
| wr_data | output | 8 | Register write data |
| wr_ack | input | 1 | Write acknowledge |
| scan_req | output | 1 | Scan request |
| scan_dark | output | 1 | 0 = clamp-level readings, 1 = dark line |
| scan_ack | input | 1 | Scan acknowledge |
| smp_valid | input | 1 | Sample valid |
| smp_data | input | 12 | Sample value |
| smp_last | input | 1 | Last pixel of a dark line |
| clamp_code | output | 4 | Current clamp code |
| done | output | 1 | Search finished successfully |
| fail | output | 1 | Search ended without a valid code |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 16-sample average, a 32-scan limit and thresholds of 102 and 204. With only 16 clamp codes, both saturation ends can be reached in 16 steps. A sensor model whose dark minimum toggles across the window runs into the 32-scan limit in under a thousand cycles. These settings also put both window edges (102, 103, 204, 205) and a sub-unity average within reach of directed scenarios.

// File: rtl/clampcal_pkg.sv
package clampcal_pkg;

  localparam int CC_ADDR_W = 3;

  localparam logic [CC_ADDR_W-1:0] CC_ADDR_OFFSET = 3'd1;
  localparam logic [CC_ADDR_W-1:0] CC_ADDR_GAIN   = 3'd2;
  localparam logic [CC_ADDR_W-1:0] CC_ADDR_CLAMP  = 3'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_GAIN,
    ST_WR_CLAMP,
    ST_SCAN,
    ST_COLLECT,
    ST_DECIDE,
    ST_WR_OFS,
    ST_DONE,
    ST_FAIL
  } cc_state_e;

endpackage

// File: rtl/clampcal_wrport.sv
// Holds one register write until it is acknowledged.
module clampcal_wrport #(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [REG_W-1:0]  ld_data,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              fin
);

  assign fin = wr_req && wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (load) begin
      wr_req  <= 1'b1;
      wr_addr <= ld_addr;
      wr_data <= ld_data;
    end else if (fin) begin
      wr_req  <= 1'b0;
    end
  end

endmodule

// File: rtl/clampcal_stats.sv
// Averages a fixed number of samples or tracks the minimum of a line.
module clampcal_stats #(
  parameter int DATA_W    = 12,
  parameter int AVG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              en,
  input  logic              dark,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_last,
  output logic [DATA_W-1:0] res,
  output logic              res_vld
);

  localparam int AVG_N = 1 << AVG_SHIFT;
  localparam int CNT_W = AVG_SHIFT + 1;
  localparam int SUM_W = DATA_W + AVG_SHIFT;

  logic [SUM_W-1:0]  sum_q, sum_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] min_q, min_nxt;
  logic              fin_q;
  logic              take;

  assign take    = en && smp_valid && !fin_q;
  assign sum_nxt = sum_q + SUM_W'(smp_data);
  assign min_nxt = (smp_data < min_q) ? smp_data : min_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sum_q   <= '0;
      cnt_q   <= '0;
      min_q   <= '1;
      fin_q   <= 1'b0;
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      if (take) begin
        if (dark) begin
          min_q <= min_nxt;
          if (smp_last) begin
            res     <= min_nxt;
            res_vld <= 1'b1;
            fin_q   <= 1'b1;
          end
        end else begin
          sum_q <= sum_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(AVG_N - 1)) begin
            res     <= DATA_W'(sum_nxt >> AVG_SHIFT);
            res_vld <= 1'b1;
            fin_q   <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/clampcal_ctrl.sv
module clampcal_ctrl
  import clampcal_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CODE_W      = 4,
  parameter int REG_W       = 8,
  parameter int AVG_SHIFT   = 4,
  parameter int MAX_SCANS   = 32,
  parameter int LOW_TH      = 102,
  parameter int HIGH_TH     = 204,
  parameter int GAIN_UNITY  = 1,
  parameter int OFFSET_ZERO = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 wr_req,
  output logic [CC_ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]     wr_data,
  input  logic                 wr_ack,
  output logic                 scan_req,
  output logic                 scan_dark,
  input  logic                 scan_ack,
  input  logic                 smp_valid,
  input  logic [DATA_W-1:0]    smp_data,
  input  logic                 smp_last,
  output logic [CODE_W-1:0]    clamp_code,
  output logic                 done,
  output logic                 fail
);

  localparam int SCAN_W = $clog2(MAX_SCANS + 1);
  localparam logic [CODE_W-1:0] CODE_TOP  = '1;
  localparam logic [DATA_W-1:0] LOW_Q     = DATA_W'(LOW_TH);
  localparam logic [DATA_W-1:0] HIGH_Q    = DATA_W'(HIGH_TH);
  localparam logic [SCAN_W-1:0] SCAN_LIM  = SCAN_W'(MAX_SCANS);
  localparam logic [REG_W-1:0]  GAIN_D    = REG_W'(GAIN_UNITY);
  localparam logic [REG_W-1:0]  OFS_D     = REG_W'(OFFSET_ZERO);

  cc_state_e            st_q;
  logic                 dark_q;
  logic [SCAN_W-1:0]    scans_q;
  logic                 ld_q;
  logic [CC_ADDR_W-1:0] ld_addr_q;
  logic [REG_W-1:0]     ld_data_q;
  logic                 wr_fin;
  logic [DATA_W-1:0]    res;
  logic                 res_vld;
  logic                 go_up, go_dn, go_dark, go_ofs, blocked;
  logic [CODE_W-1:0]    code_step;

  clampcal_wrport #(.ADDR_W(CC_ADDR_W), .REG_W(REG_W)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .load    (ld_q),
    .ld_addr (ld_addr_q),
    .ld_data (ld_data_q),
    .wr_ack  (wr_ack),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .fin     (wr_fin)
  );

  clampcal_stats #(.DATA_W(DATA_W), .AVG_SHIFT(AVG_SHIFT)) u_stats (
    .clk       (clk),
    .rst       (rst),
    .clear     (st_q == ST_SCAN),
    .en        (st_q == ST_COLLECT),
    .dark      (dark_q),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_last  (smp_last),
    .res       (res),
    .res_vld   (res_vld)
  );

  assign scan_dark = dark_q;

  // Step decision from the latest reading.
  always_comb begin
    go_up   = 1'b0;
    go_dn   = 1'b0;
    go_dark = 1'b0;
    go_ofs  = 1'b0;
    if (!dark_q) begin
      if (res != '0) go_dark = 1'b1;
      else           go_dn   = 1'b1;
    end else if (res <= LOW_Q) begin
      go_up = 1'b1;
    end else if (res > HIGH_Q) begin
      go_dn = 1'b1;
    end else begin
      go_ofs = 1'b1;
    end
    blocked = (scans_q >= SCAN_LIM)
           || (go_up && clamp_code == CODE_TOP)
           || (go_dn && clamp_code == '0);
    code_step = go_up ? clamp_code + 1'b1 : clamp_code - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      dark_q     <= 1'b0;
      scans_q    <= '0;
      ld_q       <= 1'b0;
      ld_addr_q  <= '0;
      ld_data_q  <= '0;
      scan_req   <= 1'b0;
      clamp_code <= CODE_TOP;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            clamp_code <= CODE_TOP;
            dark_q     <= 1'b0;
            scans_q    <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
            ld_q       <= 1'b1;
            ld_addr_q  <= CC_ADDR_GAIN;
            ld_data_q  <= GAIN_D;
            st_q       <= ST_WR_GAIN;
          end
        end
        ST_WR_GAIN: begin
          if (wr_fin) begin
            ld_q      <= 1'b1;
            ld_addr_q <= CC_ADDR_CLAMP;
            ld_data_q <= REG_W'(clamp_code);
            st_q      <= ST_WR_CLAMP;
          end
        end
        ST_WR_CLAMP: begin
          if (wr_fin) begin
            scan_req <= 1'b1;
            st_q     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_ack) begin
            scan_req <= 1'b0;
            scans_q  <= scans_q + 1'b1;
            st_q     <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (res_vld) st_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (go_ofs) begin
            ld_q      <= 1'b1;
            ld_addr_q <= CC_ADDR_OFFSET;
            ld_data_q <= OFS_D;
            st_q      <= ST_WR_OFS;
          end else if (blocked) begin
            fail <= 1'b1;
            st_q <= ST_FAIL;
          end else if (go_dark) begin
            dark_q   <= 1'b1;
            scan_req <= 1'b1;
            st_q     <= ST_SCAN;
          end else begin
            clamp_code <= code_step;
            ld_q       <= 1'b1;
            ld_addr_q  <= CC_ADDR_CLAMP;
            ld_data_q  <= REG_W'(code_step);
            st_q       <= ST_WR_CLAMP;
          end
        end
        ST_WR_OFS: begin
          if (wr_fin) begin
            done <= 1'b1;
            st_q <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clampcal_checker.sv
module clampcal_checker
  import clampcal_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int REG_W       = 8,
  parameter int MAX_SCANS   = 32,
  parameter int OFFSET_ZERO = 128
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 wr_req,
  input logic [CC_ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]     wr_data,
  input logic                 wr_ack,
  input logic                 scan_req,
  input logic                 scan_dark,
  input logic                 scan_ack,
  input logic [CODE_W-1:0]    clamp_code,
  input logic                 done,
  input logic                 fail
);

  localparam int CNT_W = $clog2(MAX_SCANS + 2) + 1;

  logic [CNT_W-1:0] run_scans;

  always_ff @(posedge clk) begin
    if (rst)
      run_scans <= '0;
    else if (wr_req && wr_ack && wr_addr == CC_ADDR_GAIN)
      run_scans <= '0;
    else if (scan_req && scan_ack)
      run_scans <= run_scans + 1'b1;
  end

  p_no_scan_during_write_r3: assert property (@(posedge clk) disable iff (rst)
    !(scan_req && wr_req));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_scan_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (scan_req && !scan_ack) |=> (scan_req && $stable(scan_dark)));

  p_code_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(clamp_code) |-> ($past(start)
      || clamp_code == $past(clamp_code) + 1'b1
      || clamp_code == $past(clamp_code) - 1'b1));

  p_done_offset_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(wr_req && wr_ack && wr_addr == CC_ADDR_OFFSET
                          && wr_data == REG_W'(OFFSET_ZERO)));

  p_fail_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (fail || done) |-> (!wr_req && !scan_req));

  p_scan_limit_r10: assert property (@(posedge clk) disable iff (rst)
    run_scans <= CNT_W'(MAX_SCANS));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

endmodule

bind clampcal_ctrl clampcal_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_ack     (wr_ack),
  .scan_req   (scan_req),
  .scan_dark  (scan_dark),
  .scan_ack   (scan_ack),
  .clamp_code (clamp_code),
  .done       (done),
  .fail       (fail)
);

// File: tb/tb_clampcal_ctrl.sv
module tb_clampcal_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 8;
  localparam int WDOG       = 150000;
  localparam int NSC        = 8;

  // Sensor model per scenario: average reading is non-zero when code <= ZA,
  // dark minimum = BASE + SLOPE*code clipped to 0..4095.
  localparam int SC_ZA    [NSC] = '{10,   15,  15,  15,  15, -1,  15,  3};
  localparam int SC_BASE  [NSC] = '{-200, 0,   204, 102, 205, 0,   100, 103};
  localparam int SC_SLOPE [NSC] = '{30,   100, 0,   0,   0,   0,   110, 0};
  localparam int EX_CODE  [NSC] = '{11,   2,   15,  15,  0,   0,   1,   3};
  localparam int EX_FAIL  [NSC] = '{0,    0,   0,   1,   1,   1,   1,   0};
  localparam int EX_SCANS [NSC] = '{8,    15,  2,   2,   17,  16,  32,  14};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wr_req;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ack = 1'b0;
  logic        scan_req;
  logic        scan_dark;
  logic        scan_ack = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        smp_last = 1'b0;
  logic [3:0]  clamp_code;
  logic        done;
  logic        fail;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int cur = 0;
  int wcount, first_addr, first_data, last_addr, last_data, last_clamp;
  int scan_cnt, avg_cnt, viol;
  int s_code, s_len, s_dmin, s_val;
  bit s_dark;

  clampcal_ctrl dut (
    .clk(clk), .rst(rst), .start(start),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .scan_req(scan_req), .scan_dark(scan_dark), .scan_ack(scan_ack),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_last(smp_last),
    .clamp_code(clamp_code), .done(done), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) if (!rst && scan_req && wr_req) viol = viol + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dark_min(input int idx, input int code);
    int v;
    v = SC_BASE[idx] + SC_SLOPE[idx] * code;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic string sc_req(input int idx);
    case (idx)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R9";
      5: return "R4";
      6: return "R10";
      default: return "R8";
    endcase
  endfunction

  // Register responder: acknowledges each write one cycle after seeing it.
  initial begin
    forever begin
      @(negedge clk);
      if (wr_req && !rst) begin
        @(negedge clk);
        wcount = wcount + 1;
        if (wcount == 1) begin
          first_addr = int'(wr_addr);
          first_data = int'(wr_data);
        end
        last_addr = int'(wr_addr);
        last_data = int'(wr_data);
        if (wr_addr == 3'd3) last_clamp = int'(wr_data);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
      end
    end
  end

  // Scan source: clamp-level readings or a dark line, with valid gaps.
  initial begin
    forever begin
      @(negedge clk);
      if (scan_req && !rst) begin
        s_dark = scan_dark;
        s_code = last_clamp;
        scan_cnt = scan_cnt + 1;
        if (!s_dark) avg_cnt = avg_cnt + 1;
        @(negedge clk);
        scan_ack = 1'b1;
        @(negedge clk);
        scan_ack = 1'b0;
        s_len = s_dark ? LINE_LEN : 16;
        s_dmin = dark_min(cur, s_code);
        for (int i = 0; i < s_len; i++) begin
          if (i % 3 == 2) begin
            smp_valid = 1'b0;
            @(negedge clk);
          end
          if (s_dark) begin
            s_val = (i == (s_code % LINE_LEN)) ? s_dmin : s_dmin + 300 + i;
            if (s_val > 4095) s_val = 4095;
          end else if (s_code <= SC_ZA[cur]) begin
            s_val = (i % 2 == 1) ? 50 : 30;
          end else begin
            s_val = (i == 7) ? 15 : 0;
          end
          smp_valid = 1'b1;
          smp_data  = 12'(s_val);
          smp_last  = s_dark ? (i == s_len - 1) : 1'b1;
          @(negedge clk);
        end
        smp_valid = 1'b0;
        smp_last  = 1'b0;
      end
    end
  end

  task automatic run_scn(input int idx);
    int n;
    int exp_avg;
    cur = idx;
    wcount = 0; scan_cnt = 0; avg_cnt = 0; viol = 0; last_clamp = 15;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(done || fail) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    exp_avg = (SC_ZA[idx] < 0) ? 16 : 16 - SC_ZA[idx];
    chk(first_addr == 2 && first_data == 1, "R2 first write gain=1", first_addr*256+first_data, 2*256+1);
    chk(fail == EX_FAIL[idx][0], {sc_req(idx), " fail flag"}, int'(fail), EX_FAIL[idx]);
    chk(done == !EX_FAIL[idx][0], {sc_req(idx), " done flag"}, int'(done), 1 - EX_FAIL[idx]);
    chk(int'(clamp_code) == EX_CODE[idx], {sc_req(idx), " final clamp code"}, int'(clamp_code), EX_CODE[idx]);
    chk(last_clamp == EX_CODE[idx], "R3 clamp register mirrors code", last_clamp, EX_CODE[idx]);
    chk(scan_cnt == EX_SCANS[idx], "R10 scan count", scan_cnt, EX_SCANS[idx]);
    chk(avg_cnt == exp_avg, "R4 average-phase scans", avg_cnt, exp_avg);
    chk(scan_cnt - avg_cnt == EX_SCANS[idx] - exp_avg, "R5 dark-line scans",
        scan_cnt - avg_cnt, EX_SCANS[idx] - exp_avg);
    chk(viol == 0, "R3 scan and write overlap", viol, 0);
    if (EX_FAIL[idx] == 0)
      chk(last_addr == 1 && last_data == 128, "R8 offset write 0x80 at addr 1",
          last_addr*256+last_data, 1*256+128);
    else
      chk(last_addr == 3, "R9 no write after fail", last_addr, 3);
    repeat (4) @(negedge clk);
    chk(done == !EX_FAIL[idx][0] && fail == EX_FAIL[idx][0] && !scan_req && !wr_req,
        "R11 status held", int'({done, fail}), (EX_FAIL[idx] != 0) ? 1 : 2);
  endtask

  initial begin
    wcount = 0; scan_cnt = 0; avg_cnt = 0; viol = 0; last_clamp = 15;
    first_addr = 0; first_data = 0; last_addr = 0; last_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_req && !scan_req && !done && !fail, "R1 reset outputs idle",
        int'({wr_req, scan_req, done, fail}), 0);
    chk(clamp_code == 4'hF, "R1 reset clamp code", int'(clamp_code), 15);

    for (int k = 0; k < NSC; k++) run_scn(k);

    // Second write of a run is the clamp register at all ones (R2).
    cur = 1;
    wcount = 0; last_clamp = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (wcount < 2) @(negedge clk);
    chk(last_addr == 3 && last_data == 15, "R2 second write clamp=15",
        last_addr*256+last_data, 3*256+15);

    // Reset in the middle of a run.
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_req && !scan_req && !done && !fail && clamp_code == 4'hF,
        "R1 reset mid-run", int'({wr_req, scan_req, done, fail, clamp_code}), 15);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule